// File: doc/BRIEF.md
# Priority-Ordered Test-Bus Bandwidth Allocator

This block shares a fixed test-bus bandwidth budget among cores whose tests are ready to resume after cooling. Each requesting core is ranked by a score equal to its remaining pattern count multiplied by its defect-probability weight, divided by its present temperature. Cores that still have much to test, are likely to fail, and run cool are therefore served first.

The allocator grants one core per cycle, always the top-ranked remaining candidate. Each grant removes that core's width from the budget. When the top candidate does not fit, or nothing is left, the round halts. A smaller, lower-ranked request is never served ahead of it. A halted round resumes only when bandwidth comes back through a release pulse or when another core newly raises its ready flag. A core holds its width until its release pulse, and that pulse returns the width to the budget in the same cycle.

Top module: `bw_prio_alloc`

## Requirements
- R1: After reset no grant pulse is raised and `bw_left` equals `bw_limit`. At all times `bw_left` equals `bw_limit` minus the sum of the widths latched by cores that currently hold bandwidth.
- R2: A grant decided in a cycle appears as a one-cycle pulse on that core's `grant_pulse` bit after the next rising edge. From that edge on, the core's width is subtracted from `bw_left`. A core is not granted again while it holds bandwidth, even if its ready flag stays high.
- R3: A candidate is a ready core that holds no bandwidth. The top candidate has the highest score pattern×weight/temperature. The comparison is done by cross-multiplication, so i outranks j when pat_i·wt_i·temp_j exceeds pat_j·wt_j·temp_i. On equal products the lower core index wins.
- R4: At most one `grant_pulse` bit is high in any cycle. Several candidates that all fit are granted on consecutive cycles in descending score order.
- R5: If the top candidate's width exceeds the available budget, no core is granted, including smaller lower-ranked ones.
- R6: When the available budget is zero, no grant is made, even to a zero-width request.
- R7: A release pulse on a holding core returns its width in the same cycle, so the grant decision in that cycle may already use it.
- R8: A release pulse for a core that holds no bandwidth has no effect on `bw_left` or on the grants.
- R9: Once a round has halted (R5 or R6), it stays halted, even if scores change. It reopens only in a cycle with a release pulse or a newly rising ready flag.
- R10: `bw_left` never exceeds `bw_limit`, and the held widths never exceed `bw_limit` while the limit is steady and each width is at most the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | input | N_CORES | Core is cooled and wants bandwidth (level) |
| req_width | input | N_CORES×W_BW | Bandwidth each core needs |
| rem_pat | input | N_CORES×W_PAT | Remaining pattern count per core |
| dp_wt | input | N_CORES×W_DP | Defect-probability weight per core |
| core_temp | input | N_CORES×W_TEMP | Current temperature code per core |
| release_pulse | input | N_CORES | One-cycle pulse: core returns its bandwidth |
| bw_limit | input | W_BW | Total bandwidth budget |
| grant_pulse | output | N_CORES | One-cycle grant per core |
| bw_left | output | W_BW | Budget not held by any core |

## Verification
The delicate coincidence is a release and a grant falling in the same cycle. A core is blocked behind an oversized top candidate, and the holder's release pulse must both refill the budget and let that candidate win on the very same edge. The bench holds the blocked state for several cycles and then pulses the release. It then checks that the grant appears right after that edge and that `bw_left` reflects the returned and the newly taken width together. A second coincidence comes from changing temperatures while halted and raising a new ready flag. The bench checks that the reordered winner is granted only on the cycle the new flag rises.

// File: rtl/bw_prio_pkg.sv
package bw_prio_pkg;

   typedef enum logic {
      ROUND_OPEN   = 1'b0,
      ROUND_HALTED = 1'b1
   } round_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bw_prio_pick.sv
module bw_prio_pick #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned W_PAT   = 8,
   parameter int unsigned W_DP    = 4,
   parameter int unsigned W_TEMP  = 8,
   localparam int unsigned IDX_W  = bw_prio_pkg::idx_bits(N_CORES),
   localparam int unsigned PROD_W = W_PAT + W_DP + W_TEMP
) (
   input  logic [N_CORES-1:0]             cand,
   input  logic [N_CORES-1:0][W_PAT-1:0]  rem_pat,
   input  logic [N_CORES-1:0][W_DP-1:0]   dp_wt,
   input  logic [N_CORES-1:0][W_TEMP-1:0] core_temp,
   output logic                           best_valid,
   output logic [IDX_W-1:0]               best_idx
);

   logic [PROD_W-1:0] lhs;
   logic [PROD_W-1:0] rhs;

   always_comb begin
      best_valid = 1'b0;
      best_idx   = '0;
      lhs        = '0;
      rhs        = '0;
      for (int i = 0; i < N_CORES; i++) begin
         if (cand[i]) begin
            lhs = PROD_W'(rem_pat[i]) * PROD_W'(dp_wt[i]) * PROD_W'(core_temp[best_idx]);
            rhs = PROD_W'(rem_pat[best_idx]) * PROD_W'(dp_wt[best_idx]) * PROD_W'(core_temp[i]);
            if (!best_valid || (lhs > rhs)) begin
               best_valid = 1'b1;
               best_idx   = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/bw_prio_ledger.sv
module bw_prio_ledger #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned W_BW    = 6,
   localparam int unsigned SUM_W  = W_BW + bw_prio_pkg::idx_bits(N_CORES) + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_CORES-1:0]           grant_vec,
   input  logic [N_CORES-1:0]           release_pulse,
   input  logic [N_CORES-1:0][W_BW-1:0] req_width,
   input  logic [W_BW-1:0]              bw_limit,
   output logic [N_CORES-1:0]           held,
   output logic [W_BW-1:0]              avail,
   output logic [W_BW-1:0]              bw_left
);

   logic [N_CORES-1:0][W_BW-1:0] held_w;
   logic [SUM_W-1:0]             sum_all;
   logic [SUM_W-1:0]             sum_keep;

   for (genvar g = 0; g < N_CORES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held[g]   <= 1'b0;
            held_w[g] <= '0;
         end else if (grant_vec[g]) begin
            held[g]   <= 1'b1;
            held_w[g] <= req_width[g];
         end else if (release_pulse[g]) begin
            held[g]   <= 1'b0;
            held_w[g] <= '0;
         end
      end
   end

   always_comb begin
      sum_all  = '0;
      sum_keep = '0;
      for (int i = 0; i < N_CORES; i++) begin
         if (held[i])                     sum_all  = sum_all  + SUM_W'(held_w[i]);
         if (held[i] && !release_pulse[i]) sum_keep = sum_keep + SUM_W'(held_w[i]);
      end
      bw_left = (SUM_W'(bw_limit) >= sum_all)  ? W_BW'(SUM_W'(bw_limit) - sum_all)  : '0;
      avail   = (SUM_W'(bw_limit) >= sum_keep) ? W_BW'(SUM_W'(bw_limit) - sum_keep) : '0;
   end

endmodule

// File: rtl/bw_prio_round.sv
module bw_prio_round #(
   parameter int unsigned N_CORES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CORES-1:0] req_ready,
   input  logic [N_CORES-1:0] release_pulse,
   input  logic               head_valid,
   input  logic               head_fits,
   output logic               round_open
);
   import bw_prio_pkg::*;

   round_e             state;
   logic [N_CORES-1:0] ready_q;
   logic               reopen;

   assign reopen     = (|release_pulse) || (|(req_ready & ~ready_q));
   assign round_open = (state == ROUND_OPEN) || reopen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ROUND_OPEN;
         ready_q <= '0;
      end else begin
         ready_q <= req_ready;
         if (round_open)
            state <= (head_valid && !head_fits) ? ROUND_HALTED : ROUND_OPEN;
      end
   end

endmodule

// File: rtl/bw_prio_alloc.sv
module bw_prio_alloc #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned W_BW    = 6,
   parameter int unsigned W_PAT   = 8,
   parameter int unsigned W_DP    = 4,
   parameter int unsigned W_TEMP  = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_CORES-1:0]             req_ready,
   input  logic [N_CORES-1:0][W_BW-1:0]   req_width,
   input  logic [N_CORES-1:0][W_PAT-1:0]  rem_pat,
   input  logic [N_CORES-1:0][W_DP-1:0]   dp_wt,
   input  logic [N_CORES-1:0][W_TEMP-1:0] core_temp,
   input  logic [N_CORES-1:0]             release_pulse,
   input  logic [W_BW-1:0]                bw_limit,
   output logic [N_CORES-1:0]             grant_pulse,
   output logic [W_BW-1:0]                bw_left
);
   localparam int unsigned IDX_W = bw_prio_pkg::idx_bits(N_CORES);

   initial begin
      assert (N_CORES >= 2 && W_BW >= 1 && W_PAT >= 1 && W_DP >= 1 && W_TEMP >= 1)
         else $error("bw_prio_alloc: illegal parameter set");
   end

   logic [N_CORES-1:0] held;
   logic [N_CORES-1:0] cand;
   logic [N_CORES-1:0] grant_vec;
   logic [W_BW-1:0]    avail;
   logic               best_valid;
   logic [IDX_W-1:0]   best_idx;
   logic               head_fits;
   logic               round_open;

   assign cand      = req_ready & ~held;
   assign head_fits = (avail != '0) && (req_width[best_idx] <= avail);
   assign grant_vec = (best_valid && head_fits && round_open) ? (N_CORES'(1) << best_idx) : '0;

   bw_prio_pick #(
      .N_CORES(N_CORES), .W_PAT(W_PAT), .W_DP(W_DP), .W_TEMP(W_TEMP)
   ) u_pick (
      .cand(cand), .rem_pat(rem_pat), .dp_wt(dp_wt), .core_temp(core_temp),
      .best_valid(best_valid), .best_idx(best_idx)
   );

   bw_prio_ledger #(.N_CORES(N_CORES), .W_BW(W_BW)) u_ledger (
      .clk(clk), .rst_n(rst_n), .grant_vec(grant_vec), .release_pulse(release_pulse),
      .req_width(req_width), .bw_limit(bw_limit), .held(held), .avail(avail),
      .bw_left(bw_left)
   );

   bw_prio_round #(.N_CORES(N_CORES)) u_round (
      .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .release_pulse(release_pulse),
      .head_valid(best_valid), .head_fits(head_fits), .round_open(round_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) grant_pulse <= '0;
      else        grant_pulse <= grant_vec;
   end

endmodule

// File: rtl/bw_prio_alloc_chk.sv
module bw_prio_alloc_chk #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned W_BW    = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_CORES-1:0] req_ready,
   input logic [N_CORES-1:0] release_pulse,
   input logic [W_BW-1:0]    bw_limit,
   input logic [N_CORES-1:0] grant_pulse,
   input logic [W_BW-1:0]    bw_left
);

   assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_pulse));

   assert_grant_was_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_pulse != '0) |-> ((grant_pulse & ~$past(req_ready)) == '0));

   assert_budget_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bw_left <= bw_limit);

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_pulse == '0) && ($past(release_pulse) == '0) && $stable(bw_limit))
         |-> $stable(bw_left));

   assert_grant_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_pulse != '0) && ($past(release_pulse) == '0) && $stable(bw_limit))
         |-> (bw_left <= $past(bw_left)));

endmodule

bind bw_prio_alloc bw_prio_alloc_chk #(.N_CORES(N_CORES), .W_BW(W_BW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .release_pulse(release_pulse),
   .bw_limit(bw_limit), .grant_pulse(grant_pulse), .bw_left(bw_left)
);

// File: tb/tb_bw_prio_alloc.sv
module tb_bw_prio_alloc;
   localparam int N = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [N-1:0]         req_ready = '0;
   logic [N-1:0][5:0]    req_width = '0;
   logic [N-1:0][7:0]    rem_pat = '0;
   logic [N-1:0][3:0]    dp_wt = '0;
   logic [N-1:0][7:0]    core_temp = '0;
   logic [N-1:0]         release_pulse = '0;
   logic [5:0]           bw_limit = 6'd12;
   logic [N-1:0]         grant_pulse;
   logic [5:0]           bw_left;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   bw_prio_alloc dut (
      .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_width(req_width),
      .rem_pat(rem_pat), .dp_wt(dp_wt), .core_temp(core_temp),
      .release_pulse(release_pulse), .bw_limit(bw_limit),
      .grant_pulse(grant_pulse), .bw_left(bw_left)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic defaults();
      for (int i = 0; i < N; i++) begin
         req_width[i] = 6'd1; rem_pat[i] = 8'd1; dp_wt[i] = 4'd1; core_temp[i] = 8'd1;
      end
   endtask

   task automatic cleanup();
      req_ready = '0; release_pulse = '1;
      tick();
      release_pulse = '0;
      tick();
      defaults();
   endtask

   task automatic expect_gb(input logic [N-1:0] g, input int b, input string req);
      chk(grant_pulse == g, {req, " grant"}, grant_pulse, g);
      chk(bw_left == b, {req, " bw_left"}, bw_left, b);
   endtask

   function automatic int pv(input int k);
      case (k) 0: return 1; 1: return 2; 2: return 3; default: return 5; endcase
   endfunction
   function automatic int tv(input int k);
      case (k) 0: return 1; 1: return 2; default: return 4; endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      defaults();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      expect_gb('0, 12, "R1 reset");

      // R2: grant, subtraction, no regrant while held
      req_width[2] = 6'd5; req_ready = 4'b0100;
      tick(); expect_gb(4'b0100, 7, "R2 first grant");
      tick(); expect_gb(4'b0000, 7, "R2 no regrant");
      req_ready = '0; release_pulse = 4'b0100;
      tick(); release_pulse = '0;
      tick(); expect_gb(4'b0000, 12, "R1 width returned");
      cleanup();

      // R3/R4: order and one grant per cycle
      for (int i = 0; i < N; i++) req_width[i] = 6'd2;
      rem_pat[0] = 8'd1; rem_pat[1] = 8'd5; rem_pat[3] = 8'd9;
      req_ready = 4'b1011;
      tick(); expect_gb(4'b1000, 10, "R3 R4 first");
      tick(); expect_gb(4'b0010, 8,  "R3 R4 second");
      tick(); expect_gb(4'b0001, 6,  "R3 R4 third");
      tick(); expect_gb(4'b0000, 6,  "R4 done");
      cleanup();

      // R5/R7: head blocking, then release frees it in the same cycle
      req_width[0] = 6'd8; req_ready = 4'b0001;
      tick(); expect_gb(4'b0001, 4, "R5 setup");
      req_width[1] = 6'd6; rem_pat[1] = 8'd9; req_width[2] = 6'd2;
      req_ready = 4'b0110;
      tick(); expect_gb(4'b0000, 4, "R5 blocked");
      tick(); expect_gb(4'b0000, 4, "R5 still blocked");
      release_pulse = 4'b0001;
      tick(); expect_gb(4'b0010, 6, "R7 release and grant");
      release_pulse = '0;
      tick(); expect_gb(4'b0100, 4, "R5 next in order");
      cleanup();

      // R9: halted round ignores reordering until a new ready rises
      req_width[0] = 6'd8; req_ready = 4'b0001;
      tick(); expect_gb(4'b0001, 4, "R9 setup");
      req_width[1] = 6'd6; rem_pat[1] = 8'd9; req_width[2] = 6'd2;
      req_ready = 4'b0110;
      tick(); expect_gb(4'b0000, 4, "R9 halted");
      core_temp[1] = 8'd200;
      tick(); expect_gb(4'b0000, 4, "R9 reorder ignored");
      tick(); expect_gb(4'b0000, 4, "R9 reorder ignored again");
      rem_pat[3] = 8'd0; req_ready = 4'b1110;
      tick(); expect_gb(4'b0100, 2, "R9 reopened by rising ready");
      tick(); expect_gb(4'b0000, 2, "R5 R9 halted again");
      tick(); expect_gb(4'b0000, 2, "R5 lower not served");
      cleanup();

      // R6: zero budget blocks zero-width request
      req_width[0] = 6'd12; req_ready = 4'b0001;
      tick(); expect_gb(4'b0001, 0, "R6 fill");
      req_width[1] = 6'd0; req_ready = 4'b0010;
      tick(); expect_gb(4'b0000, 0, "R6 no grant at zero");
      tick(); expect_gb(4'b0000, 0, "R6 still none");
      cleanup();

      // R8: release of a non-holding core ignored
      req_width[0] = 6'd5; req_ready = 4'b0001;
      tick(); expect_gb(4'b0001, 7, "R8 setup");
      release_pulse = 4'b1000;
      tick(); release_pulse = '0;
      tick(); expect_gb(4'b0000, 7, "R8 stray release");
      cleanup();

      // R3 sweep over two cores
      for (int a = 0; a < 24; a++) begin
         for (int b = 0; b < 24; b++) begin
            int pa, da, ta, pb, db, tb, sa, sb;
            logic [N-1:0] exp_g;
            pa = pv(a % 4); da = ((a / 4) % 2) ? 3 : 1; ta = tv(a / 8);
            pb = pv(b % 4); db = ((b / 4) % 2) ? 3 : 1; tb = tv(b / 8);
            sa = pa * da * tb; sb = pb * db * ta;
            exp_g = (sa >= sb) ? 4'b0001 : 4'b0010;
            rem_pat[0] = 8'(pa); dp_wt[0] = 4'(da); core_temp[0] = 8'(ta);
            rem_pat[1] = 8'(pb); dp_wt[1] = 4'(db); core_temp[1] = 8'(tb);
            req_ready = 4'b0011;
            tick();
            chk(grant_pulse == exp_g, "R3 sweep winner", grant_pulse, exp_g);
            req_ready = '0; release_pulse = 4'b0011;
            tick(); release_pulse = '0;
            tick();
         end
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule